// File: doc/BRIEF.md
# Instruction Namespace Select Register with Trap Save and Restore

This block holds the control state that tells an instruction decoder which opcode namespace is active. For each privilege level (user, supervisor, machine) there is a live namespace register and a shadow register. The shadow holds the namespace that was in force when the last trap into that level was taken. It is handled like that level's saved-PC and cause registers: trap entry fills it, trap return reads it, and software may overwrite it before returning.

On a trap-entry strobe the block copies the live namespace of the interrupted level into the shadow of the handling level and forces the handling level's live namespace to the base value 0. On a trap-return strobe it copies the handling level's shadow into the live register of the level being returned to. This update happens on the same clock edge that the pipeline loads the saved PC, so the new namespace and the new PC take effect together. Software writes are checked against a fixed list of supported namespace IDs. An unsupported value raises an illegal-write exception and changes nothing. It is never rounded to some legal value. A one-cycle pulse tells the decoder to flush whenever the namespace it sees changes.

Top module: `nsel_trap_unit`

## Requirements
- R1: After reset every live and shadow register reads 0, `ns_o` is 0 and `ns_switch_o` is low.
- R2: A CSR write with `csr_addr_i[2]`=0 and a legal value loads the live register of level `csr_addr_i[1:0]` (0=user, 1=supervisor, 3=machine). The new value reads back, and shows on `ns_o` when `cur_lvl_i` selects that level, from the next cycle on.
- R3: A value is legal when it is 0 or one of the `LEGAL_IDS` entries (defaults 32'h0000_0005, 32'h0000_0100 and 32'h8000_0001). A CSR write with any other value, or to level 2, raises `csr_illegal_o` in the same cycle and leaves every register unchanged.
- R4: A CSR write with `csr_addr_i[2]`=1 targets the shadow register of the addressed level, under the same legality rule.
- R5: A trap-entry strobe to level T (T≠2) copies the live value of level `cur_lvl_i` into the shadow of T and sets the live value of T to 0, both visible in the next cycle.
- R6: A trap-return strobe from level T to level `ret_lvl_i` (neither 2) loads the shadow of T into the live register of `ret_lvl_i` at the clock edge that ends the strobe cycle. This is the same edge at which the saved PC is loaded. The shadow keeps its value.
- R7: A CSR write in a cycle with a trap-entry or trap-return strobe is discarded and does not raise `csr_illegal_o`. Trap strobes that name level 2 change nothing.
- R8: `ns_switch_o` is high in exactly those cycles in which `ns_o` differs from its value in the previous cycle.
- R9: If trap entry and trap return are strobed in the same cycle, only the trap entry takes effect.
- R10: Level code 2 is reserved: both level-2 addresses read 0, and a write to them is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_lvl_i | input | 2 | Privilege level currently executing |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 3 | Bit 2: 0 = live, 1 = shadow; bits 1:0: level |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Contents of the addressed register |
| csr_illegal_o | output | 1 | Illegal-write exception for the current write |
| trap_enter_i | input | 1 | Trap-entry strobe |
| trap_ret_i | input | 1 | Trap-return strobe |
| trap_lvl_i | input | 2 | Level that takes or returns from the trap |
| ret_lvl_i | input | 2 | Level being returned to |
| ns_o | output | 32 | Live namespace of `cur_lvl_i` |
| ns_switch_o | output | 1 | One-cycle pulse when `ns_o` changes |

## Verification
The bench drives every address with zero, each supported ID, the values on either side of each ID and all 32 walking-one patterns. A design that coerced values, or that stored them in spite of the exception, would show a wrong readback. Each combination of interrupted level and handling level is taken through trap entry and return. This exposes a save from the wrong level, a missing force to base, or a restore into the wrong live register. Collision cycles cover a write during a trap, entry and return strobed together, and trap strobes that name the reserved level. A design that let the CSR write win would leave a stored value or raise a false exception in these cases. The flush pulse is compared every cycle, so a pulse that is missing, extra or one cycle late is caught.

// File: rtl/nsel_pkg.sv
package nsel_pkg;
    localparam int NS_W    = 32;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef logic [NS_W-1:0]  ns_t;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam ns_t  NS_BASE = '0;
    localparam lvl_t LVL_RSV = 2'd2;

    typedef struct packed {
        ns_t [NUM_LVL-1:0] live;
        ns_t [NUM_LVL-1:0] last;
    } bank_t;
endpackage

// File: rtl/nsel_legal_chk.sv
module nsel_legal_chk #(
    parameter int                     NS_W      = 32,
    parameter int                     NUM_IDS   = 3,
    parameter logic [NUM_IDS*NS_W-1:0] LEGAL_IDS = '0
) (
    input  logic [NS_W-1:0] value_i,
    output logic            legal_o
);
    logic [NUM_IDS-1:0] hit;

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        assign hit[i] = (value_i == LEGAL_IDS[i*NS_W +: NS_W]);
    end

    assign legal_o = (value_i == '0) || (|hit);
endmodule

// File: rtl/nsel_csr_dec.sv
module nsel_csr_dec
    import nsel_pkg::*;
(
    input  logic [LVL_W:0] addr_i,
    output logic           sel_last_o,
    output lvl_t           lvl_o,
    output logic           rsv_o
);
    assign sel_last_o = addr_i[LVL_W];
    assign lvl_o      = addr_i[LVL_W-1:0];
    assign rsv_o      = (addr_i[LVL_W-1:0] == LVL_RSV);
endmodule

// File: rtl/nsel_switch_det.sv
module nsel_switch_det #(
    parameter int NS_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NS_W-1:0] ns_i,
    output logic            pulse_o
);
    logic [NS_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = ns_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    assign pulse_o = (ns_i != prev_q);
endmodule

// File: rtl/nsel_trap_unit.sv
module nsel_trap_unit
    import nsel_pkg::*;
#(
    parameter int                      NUM_IDS   = 3,
    parameter logic [NUM_IDS*32-1:0]   LEGAL_IDS = {32'h8000_0001, 32'h0000_0100, 32'h0000_0005}
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [1:0]  cur_lvl_i,
    input  logic        csr_we_i,
    input  logic [2:0]  csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    output logic        csr_illegal_o,
    input  logic        trap_enter_i,
    input  logic        trap_ret_i,
    input  logic [1:0]  trap_lvl_i,
    input  logic [1:0]  ret_lvl_i,
    output logic [31:0] ns_o,
    output logic        ns_switch_o
);
    bank_t st_d, st_q;
    logic  wdata_legal, sel_last, rsv, trap_any, wr_ok;
    lvl_t  wr_lvl;

    nsel_legal_chk #(
        .NS_W      (NS_W),
        .NUM_IDS   (NUM_IDS),
        .LEGAL_IDS (LEGAL_IDS)
    ) legal_i (
        .value_i (csr_wdata_i),
        .legal_o (wdata_legal)
    );

    nsel_csr_dec dec_i (
        .addr_i     (csr_addr_i),
        .sel_last_o (sel_last),
        .lvl_o      (wr_lvl),
        .rsv_o      (rsv)
    );

    assign trap_any      = trap_enter_i || trap_ret_i;
    assign wr_ok         = csr_we_i && !trap_any && !rsv && wdata_legal;
    assign csr_illegal_o = csr_we_i && !trap_any && (rsv || !wdata_legal);

    always_comb begin
        st_d = st_q;
        if (trap_enter_i) begin
            if (trap_lvl_i != LVL_RSV) begin
                st_d.last[trap_lvl_i] = st_q.live[cur_lvl_i];
                st_d.live[trap_lvl_i] = NS_BASE;
            end
        end else if (trap_ret_i) begin
            if (trap_lvl_i != LVL_RSV && ret_lvl_i != LVL_RSV) begin
                st_d.live[ret_lvl_i] = st_q.last[trap_lvl_i];
            end
        end else if (wr_ok) begin
            if (sel_last) st_d.last[wr_lvl] = csr_wdata_i;
            else          st_d.live[wr_lvl] = csr_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign csr_rdata_o = rsv      ? NS_BASE :
                         sel_last ? st_q.last[wr_lvl] : st_q.live[wr_lvl];
    assign ns_o        = st_q.live[cur_lvl_i];

    nsel_switch_det #(.NS_W(NS_W)) sw_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ns_i    (ns_o),
        .pulse_o (ns_switch_o)
    );

    // An exception-raising write leaves the whole bank untouched
    assert_illegal_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |=> $stable(st_q));

    // Handling level runs under the base namespace right after entry
    assert_enter_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_enter_i && trap_lvl_i != LVL_RSV) ##1 (cur_lvl_i == $past(trap_lvl_i))
        |-> ns_o == NS_BASE);

    // Return brings the shadow value live on the PC-load edge
    assert_ret_restore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_ret_i && !trap_enter_i && trap_lvl_i != LVL_RSV && ret_lvl_i != LVL_RSV)
        ##1 (cur_lvl_i == $past(ret_lvl_i))
        |-> ns_o == $past(st_q.last[trap_lvl_i]));

    // A trap naming the reserved level changes nothing and swallows any write
    assert_rsv_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_enter_i && trap_lvl_i == LVL_RSV) |=> $stable(st_q));

    // No flush pulse when neither the view nor the state moved
    assert_no_spurious_switch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(cur_lvl_i) && $stable(st_q)) |-> !ns_switch_o);
endmodule

// File: tb/nsel_trap_unit_tb.sv
module nsel_trap_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  cur_lvl_i = '0;
    logic        csr_we_i = 1'b0;
    logic [2:0]  csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        csr_illegal_o;
    logic        trap_enter_i = 1'b0;
    logic        trap_ret_i = 1'b0;
    logic [1:0]  trap_lvl_i = '0;
    logic [1:0]  ret_lvl_i = '0;
    logic [31:0] ns_o;
    logic        ns_switch_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] mlive [4];
    logic [31:0] mlast [4];
    logic [31:0] mprev;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    nsel_trap_unit dut_i (
        .clk_i, .rst_ni, .cur_lvl_i, .csr_we_i, .csr_addr_i, .csr_wdata_i,
        .csr_rdata_o, .csr_illegal_o, .trap_enter_i, .trap_ret_i,
        .trap_lvl_i, .ret_lvl_i, .ns_o, .ns_switch_o
    );

    function automatic bit exp_legal(logic [31:0] v);
        return v == 32'h0 || v == 32'h5 || v == 32'h100 || v == 32'h8000_0001;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive one cycle, check outputs before the edge, then advance the model
    task automatic step(string tag, logic [1:0] cur, logic we, logic [2:0] addr,
                        logic [31:0] wd, logic en, logic rt, logic [1:0] tl, logic [1:0] rl);
        logic [31:0] rd_exp;
        bit ill_exp;
        @(negedge clk_i);
        cur_lvl_i = cur; csr_we_i = we; csr_addr_i = addr; csr_wdata_i = wd;
        trap_enter_i = en; trap_ret_i = rt; trap_lvl_i = tl; ret_lvl_i = rl;
        #1;
        ill_exp = we && !(en || rt) && (addr[1:0] == 2'd2 || !exp_legal(wd));
        rd_exp  = (addr[1:0] == 2'd2) ? 32'h0 : (addr[2] ? mlast[addr[1:0]] : mlive[addr[1:0]]);
        chk(tag, "illegal", {31'h0, csr_illegal_o}, {31'h0, ill_exp});
        chk(tag, "rdata", csr_rdata_o, rd_exp);
        chk(tag, "ns", ns_o, mlive[cur]);
        chk({tag, "/R8"}, "switch", {31'h0, ns_switch_o}, {31'h0, mlive[cur] != mprev});
        @(posedge clk_i);
        mprev = mlive[cur];
        if (en) begin
            if (tl != 2'd2) begin
                mlast[tl] = mlive[cur];
                mlive[tl] = 32'h0;
            end
        end else if (rt) begin
            if (tl != 2'd2 && rl != 2'd2) mlive[rl] = mlast[tl];
        end else if (we && addr[1:0] != 2'd2 && exp_legal(wd)) begin
            if (addr[2]) mlast[addr[1:0]] = wd;
            else         mlive[addr[1:0]] = wd;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] tv [42];
        logic [31:0] good [3];
        logic [1:0]  lv [3];
        good[0] = 32'h5; good[1] = 32'h100; good[2] = 32'h8000_0001;
        lv[0] = 2'd0; lv[1] = 2'd1; lv[2] = 2'd3;
        tv[0] = 32'h0;  tv[1] = 32'h5;  tv[2] = 32'h4;  tv[3] = 32'h6;
        tv[4] = 32'h100; tv[5] = 32'hff; tv[6] = 32'h101;
        tv[7] = 32'h8000_0001; tv[8] = 32'h8000_0000; tv[9] = 32'h8000_0002;
        for (int b = 0; b < 32; b++) tv[10+b] = 32'h1 << b;
        for (int i = 0; i < 4; i++) begin mlive[i] = '0; mlast[i] = '0; end
        mprev = '0;

        repeat (3) @(posedge clk_i);
        @(negedge clk_i) rst_ni = 1'b1;

        // R1 reset state, R10 reserved addresses read zero
        for (int a = 0; a < 8; a++)
            step((a[1:0] == 2'd2) ? "R10" : "R1", 2'd0, 1'b0, a[2:0], 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);

        // R2/R3/R4/R10 sweep of every address with every test value, then read back
        for (int a = 0; a < 8; a++) begin
            for (int k = 0; k < 42; k++) begin
                string tg;
                if (a[1:0] == 2'd2)         tg = "R10";
                else if (!exp_legal(tv[k])) tg = "R3";
                else if (a[2])              tg = "R4";
                else                        tg = "R2";
                step(tg, a[1:0], 1'b1, a[2:0], tv[k], 1'b0, 1'b0, 2'd0, 2'd0);
                step(tg, a[1:0], 1'b0, a[2:0], 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);
            end
        end

        // R5/R6 every interrupted level against every handling level
        for (int c = 0; c < 3; c++) begin
            for (int t = 0; t < 3; t++) begin
                logic [31:0] v;
                v = good[(c + t) % 3];
                step("R2", lv[c], 1'b1, {1'b0, lv[c]}, v, 1'b0, 1'b0, 2'd0, 2'd0);
                step("R5", lv[c], 1'b0, {1'b1, lv[t]}, 32'h0, 1'b1, 1'b0, lv[t], 2'd0);
                step("R5", lv[t], 1'b0, {1'b1, lv[t]}, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);
                step("R6", lv[t], 1'b0, {1'b0, lv[c]}, 32'h0, 1'b0, 1'b1, lv[t], lv[c]);
                step("R6", lv[c], 1'b0, {1'b1, lv[t]}, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);
            end
        end

        // R4/R6 context switch: rewrite the shadow, then return into it
        step("R4", 2'd1, 1'b1, 3'b101, 32'h100, 1'b0, 1'b0, 2'd0, 2'd0);
        step("R4", 2'd1, 1'b1, 3'b101, 32'h7, 1'b0, 1'b0, 2'd0, 2'd0);
        step("R6", 2'd1, 1'b0, 3'b101, 32'h0, 1'b0, 1'b1, 2'd1, 2'd0);
        step("R6", 2'd0, 1'b0, 3'b000, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);

        // R7 writes during trap strobes are discarded and raise nothing
        step("R7", 2'd0, 1'b1, 3'b001, 32'h5, 1'b1, 1'b0, 2'd3, 2'd0);
        step("R7", 2'd3, 1'b1, 3'b001, 32'h9, 1'b1, 1'b0, 2'd3, 2'd0);
        step("R7", 2'd3, 1'b1, 3'b111, 32'h5, 1'b0, 1'b1, 2'd3, 2'd1);
        step("R7", 2'd1, 1'b0, 3'b001, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);
        step("R7", 2'd1, 1'b1, 3'b011, 32'h8000_0001, 1'b1, 1'b0, 2'd2, 2'd0);
        step("R7", 2'd1, 1'b1, 3'b000, 32'h100, 1'b0, 1'b1, 2'd2, 2'd0);
        step("R7", 2'd1, 1'b0, 3'b011, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);

        // R9 entry and return together: entry wins
        step("R9", 2'd1, 1'b1, 3'b001, 32'h100, 1'b0, 1'b0, 2'd0, 2'd0);
        step("R9", 2'd3, 1'b1, 3'b111, 32'h5, 1'b0, 1'b0, 2'd0, 2'd0);
        step("R9", 2'd1, 1'b0, 3'b101, 32'h0, 1'b1, 1'b1, 2'd3, 2'd1);
        step("R9", 2'd3, 1'b0, 3'b111, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);
        step("R9", 2'd1, 1'b0, 3'b001, 32'h0, 1'b0, 1'b0, 2'd0, 2'd0);

        finish_run();
    end
endmodule